// File: doc/BRIEF.md
# Ten-Step Pattern Sequencer Control Core

This block is the control core of a ten-position pattern sequencer. It holds a one-hot step register and advances it on a step strobe. The strobe is the internal clock tick, taken only while the sequencer runs, ORed with the rising edge of a manual-step pulse. A run/stop flag is toggled by a start/stop button and can also be set by an external start edge. Every move from stopped to running puts the pattern back at step 1.

A position selector (1 to 10) and a three-way mode set how long the pattern is and how it ends. In free-run mode the pattern loops over all ten steps. In reset-at mode the pattern returns to step 1 instead of entering the selected step, so that step is never shown. In stop-at mode the pattern enters the selected step, clears the run flag and stays there. That arrival is marked by a one-cycle pulse for the downstream gate logic. A separate reset button moves the pattern back to step 1 and leaves the run flag alone.

All button-type inputs are acted on at their rising edge, in the same clock edge that samples them. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `ten_step_seq_ctrl`

## Requirements
- R1: Exactly one bit of `step_onehot` is high at all times. Bit i is high exactly when `step_idx` equals i, and index i stands for step i+1.
- R2: With `mode` 0 or 3 (free-run) and `running` high, each `tick` moves the index forward by one. Index 9 wraps to 0.
- R3: With `mode` 1 (reset-at) and `last_sel` N in 1..10, a strobe whose next index would be N-1 or higher sends the index to 0 instead. Step N is never shown. With N=1 the index stays at 0.
- R4: With `mode` 2 (stop-at) and `last_sel` N in 1..10, a strobe that moves the index onto N-1 clears `running` and raises `last_step_hit` for exactly that one cycle.
- R5: A rising edge of `ss_btn` sets `running` when it is low and clears it when it is high.
- R6: Every change of `running` from low to high puts the index at 0 in the same cycle.
- R7: A rising edge of `ext_start` sets `running` when it is low. When `running` is high, that edge has no effect.
- R8: A rising edge of `rst_btn` puts the index at 0 and leaves `running` unchanged.
- R9: A rising edge of `man_step` advances the index exactly like a tick, including while stopped. `tick` has no effect while `running` is low.
- R10: When `last_sel` is 0 or above 10, the block behaves as free-run whatever `mode` says.
- R11: When a start or a reset-button edge falls in the same cycle as a strobe, the index goes to 0 and the strobe is dropped.
- R12: After reset the index is 0, `running` is low and `last_step_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the internal step clock |
| man_step | input | 1 | Debounced manual-step level; advances on its rising edge |
| ss_btn | input | 1 | Start/stop button level; toggles on its rising edge |
| ext_start | input | 1 | External start level; starts on its rising edge |
| rst_btn | input | 1 | Reset button level; returns to step 1 on its rising edge |
| mode | input | 2 | 0 free-run, 1 reset-at, 2 stop-at, 3 free-run |
| last_sel | input | 4 | Selected position N, valid from 1 to 10 |
| step_onehot | output | 10 | One-hot active step |
| step_idx | output | 4 | Active step index, 0 to 9 |
| running | output | 1 | Run state |
| last_step_hit | output | 1 | One-cycle pulse when stop-at mode enters step N |

## Verification
On every cycle the assertions check that the step output stays one-hot. They check the run-flag response to the start/stop and external-start edges, that a start or reset-button edge always lands on index 0, and that reset-at mode never lands on the selected index. They also check that a stop-at arrival drops the run flag and lands on the selected index. Full pattern lengths, the wrap point of free-run, the clamp of out-of-range positions and the order of the sequence over many strobes are shown only by the bench scenarios. The bench compares every cycle against its own model of the requirements, under directed cases and a long random mix of buttons, ticks, modes and positions.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_RESET_AT = 2'd1,
    MODE_STOP_AT  = 2'd2,
    MODE_FREE_ALT = 2'd3
  } seq_mode_e;

  // Control events derived from the button edges in one cycle
  typedef struct packed {
    logic start;    // stopped -> running
    logic clear;    // force index 0 (start or reset button)
    logic advance;  // step strobe
  } seq_evt_t;

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/seq_edge_det.sv
module seq_edge_det #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_rise
    assign rise_o[g] = level_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_rise,
  input  logic ext_rise,
  input  logic stop_hit,
  output logic start_evt,
  output logic running
);

  logic run_q, run_d, run_en;

  assign start_evt = ~run_q & (ss_rise | ext_rise);

  always_comb begin
    run_d  = run_q;
    run_en = 1'b0;
    if (start_evt) begin
      run_d  = 1'b1;
      run_en = 1'b1;
    end else if (run_q && (ss_rise || stop_hit)) begin
      run_d  = 1'b0;
      run_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  assign running = run_q;

  assert_ss_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_rise && !running) |=> running);
  assert_ss_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_rise && running) |=> !running);
  assert_ext_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rise && !running) |=> running);
  assert_ext_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rise && running && !ss_rise && !stop_hit) |=> running);

endmodule

// File: rtl/seq_step_ctr.sv
module seq_step_ctr
  import seq_pkg::*;
#(
  parameter int NUM_STEPS = 10,
  parameter int IDX_W     = $clog2(NUM_STEPS),
  parameter int SEL_W     = $clog2(NUM_STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seq_evt_t             evt,
  input  seq_mode_e            mode,
  input  logic [SEL_W-1:0]     last_sel,
  output logic                 hit_now,
  output logic                 last_step_hit,
  output logic [IDX_W-1:0]     step_idx,
  output logic [NUM_STEPS-1:0] step_onehot
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);
  localparam logic [SEL_W-1:0] MAX_SEL  = SEL_W'(NUM_STEPS);

  logic [IDX_W-1:0] idx_q, idx_d, inc, tgt;
  logic [SEL_W-1:0] tgt_full;
  logic             idx_en, pos_ok, use_reset, use_stop, hit_q;

  assign pos_ok    = (last_sel != '0) && (last_sel <= MAX_SEL);
  assign tgt_full  = last_sel - SEL_W'(1);
  assign tgt       = tgt_full[IDX_W-1:0];
  assign use_reset = pos_ok && (mode == MODE_RESET_AT);
  assign use_stop  = pos_ok && (mode == MODE_STOP_AT);
  assign inc       = (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);

  always_comb begin
    idx_d   = idx_q;
    idx_en  = 1'b0;
    hit_now = 1'b0;
    if (evt.clear) begin
      idx_d  = '0;
      idx_en = 1'b1;
    end else if (evt.advance) begin
      idx_en = 1'b1;
      if (use_reset && (inc >= tgt)) begin
        idx_d = '0;
      end else begin
        idx_d   = inc;
        hit_now = use_stop && (inc == tgt);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      hit_q <= hit_now;
    end
  end

  assign step_idx      = idx_q;
  assign last_step_hit = hit_q;

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_dec
    assign step_onehot[g] = (idx_q == IDX_W'(g));
  end

  assert_never_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.advance && !evt.clear && use_reset && tgt != '0) |=> step_idx != $past(tgt));
  assert_stop_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> (last_step_hit && step_idx == $past(tgt)));
  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clear |=> step_idx == '0);

endmodule

// File: rtl/ten_step_seq_ctrl.sv
module ten_step_seq_ctrl
  import seq_pkg::*;
#(
  parameter int NUM_STEPS = 10,
  parameter int IDX_W     = $clog2(NUM_STEPS),
  parameter int SEL_W     = $clog2(NUM_STEPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 man_step,
  input  logic                 ss_btn,
  input  logic                 ext_start,
  input  logic                 rst_btn,
  input  logic [1:0]           mode,
  input  logic [SEL_W-1:0]     last_sel,
  output logic [NUM_STEPS-1:0] step_onehot,
  output logic [IDX_W-1:0]     step_idx,
  output logic                 running,
  output logic                 last_step_hit
);

  localparam int N_BTN = 4;

  logic             rst_n_sync, start_evt, hit_now;
  logic [N_BTN-1:0] rise;
  logic             man_rise, ss_rise, ext_rise, rst_rise;
  seq_evt_t         evt;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  seq_edge_det #(.WIDTH(N_BTN)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .level_i ({rst_btn, ext_start, ss_btn, man_step}),
    .rise_o  (rise)
  );

  assign man_rise = rise[0];
  assign ss_rise  = rise[1];
  assign ext_rise = rise[2];
  assign rst_rise = rise[3];

  seq_run_ctrl u_run (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .ss_rise   (ss_rise),
    .ext_rise  (ext_rise),
    .stop_hit  (hit_now),
    .start_evt (start_evt),
    .running   (running)
  );

  assign evt.start   = start_evt;
  assign evt.clear   = start_evt | rst_rise;
  assign evt.advance = (tick & running) | man_rise;

  seq_step_ctr #(
    .NUM_STEPS (NUM_STEPS),
    .IDX_W     (IDX_W),
    .SEL_W     (SEL_W)
  ) u_ctr (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .evt           (evt),
    .mode          (seq_mode_e'(mode)),
    .last_sel      (last_sel),
    .hit_now       (hit_now),
    .last_step_hit (last_step_hit),
    .step_idx      (step_idx),
    .step_onehot   (step_onehot)
  );

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $onehot(step_onehot) && step_onehot[step_idx]);
  assert_start_at_one_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(running) |-> step_idx == '0);
  assert_rstbtn_R8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (rst_rise && !ss_rise && !ext_rise) |=> (step_idx == '0 && running == $past(running)));
  assert_hit_stops_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    last_step_hit |-> !running);

endmodule

// File: tb/sim_ten_step_seq_ctrl.sv
module sim_ten_step_seq_ctrl;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, man_step = 0, ss_btn = 0, ext_start = 0, rst_btn = 0;
  logic [1:0] mode = 2'd0;
  logic [3:0] last_sel = 4'd10;
  logic [9:0] step_onehot;
  logic [3:0] step_idx;
  logic       running, last_step_hit;

  ten_step_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .man_step(man_step), .ss_btn(ss_btn),
    .ext_start(ext_start), .rst_btn(rst_btn), .mode(mode), .last_sel(last_sel),
    .step_onehot(step_onehot), .step_idx(step_idx), .running(running),
    .last_step_hit(last_step_hit)
  );

  always #(PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R12";
  bit    done = 0;

  // reference model state
  int m_idx = 0;
  bit m_run = 0, m_hit = 0;
  bit p_man = 0, p_ss = 0, p_ext = 0, p_rst = 0;

  function automatic int next_idx(int idx, bit rst_mode, int sel);
    int inc;
    inc = (idx == 9) ? 0 : idx + 1;
    if (rst_mode && inc >= sel - 1) return 0;
    return inc;
  endfunction

  task automatic model_apply(bit t, bit m, bit s, bit e, bit r, logic [1:0] md, logic [3:0] sel);
    bit s_r, e_r, m_r, r_r, start, stop, clr, adv, ok, rm, sm;
    int n;
    s_r = s & ~p_ss; e_r = e & ~p_ext; m_r = m & ~p_man; r_r = r & ~p_rst;
    start = !m_run && (s_r || e_r);
    stop  = m_run && s_r;
    clr   = start || r_r;
    adv   = (t && m_run) || m_r;
    ok    = (sel >= 1) && (sel <= 10);     // R10: otherwise free-run
    rm    = ok && md == 2'd1;
    sm    = ok && md == 2'd2;
    m_hit = 0;
    if (clr) m_idx = 0;                     // R11: clear beats strobe
    else if (adv) begin
      n = next_idx(m_idx, rm, int'(sel));
      if (sm && n == int'(sel) - 1) m_hit = 1;
      m_idx = n;
    end
    if (start) m_run = 1;
    else if (stop || m_hit) m_run = 0;
    p_ss = s; p_ext = e; p_man = m; p_rst = r;
  endtask

  task automatic compare();
    checks++;
    if (step_idx !== 4'(m_idx) || step_onehot !== (10'd1 << m_idx) ||
        running !== m_run || last_step_hit !== m_hit) begin
      errors++;
      $display("FAIL %s: idx=%0d oh=%b run=%0b hit=%0b expected idx=%0d oh=%b run=%0b hit=%0b",
               cur_req, step_idx, step_onehot, running, last_step_hit,
               m_idx, 10'd1 << m_idx, m_run, m_hit);
    end
  endtask

  task automatic cyc(bit t, bit m, bit s, bit e, bit r, logic [1:0] md, logic [3:0] sel);
    @(negedge clk);
    compare();
    tick = t; man_step = m; ss_btn = s; ext_start = e; rst_btn = r;
    mode = md; last_sel = sel;
    model_apply(t, m, s, e, r, md, sel);
  endtask

  task automatic ticks(int n, logic [1:0] md, logic [3:0] sel);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0, 0, md, sel);
      cyc(0, 0, 0, 0, 0, md, sel);
    end
  endtask

  task automatic press_ss(logic [1:0] md, logic [3:0] sel);
    cyc(0, 0, 1, 0, 0, md, sel);
    cyc(0, 0, 0, 0, 0, md, sel);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd20241);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    cur_req = "R12"; cyc(0, 0, 0, 0, 0, 2'd0, 4'd10);
    // R9: tick ignored while stopped
    cur_req = "R9"; ticks(3, 2'd0, 4'd10);
    // R5 / R6: start forces step 1
    cur_req = "R6"; press_ss(2'd0, 4'd10);
    // R2: free-run wrap
    cur_req = "R2"; ticks(12, 2'd0, 4'd10);
    cur_req = "R2"; ticks(4, 2'd3, 4'd7);
    // R10: out-of-range position acts as free-run
    cur_req = "R10"; ticks(12, 2'd1, 4'd0);
    cur_req = "R10"; ticks(6, 2'd2, 4'd15);
    // R8: reset button keeps run state
    cur_req = "R8"; cyc(0, 0, 0, 0, 1, 2'd1, 4'd4); cyc(0, 0, 0, 0, 0, 2'd1, 4'd4);
    // R3: reset-at N=4, N=1
    cur_req = "R3"; ticks(9, 2'd1, 4'd4);
    cur_req = "R3"; ticks(3, 2'd1, 4'd1);
    // R7: external start ignored while running
    cur_req = "R7"; cyc(0, 0, 0, 1, 0, 2'd0, 4'd10); cyc(0, 0, 0, 0, 0, 2'd0, 4'd10);
    // R5: stop toggle
    cur_req = "R5"; press_ss(2'd2, 4'd5);
    // R4: stop-at N=5
    cur_req = "R4"; press_ss(2'd2, 4'd5);
    cur_req = "R4"; ticks(7, 2'd2, 4'd5);
    // R7: external start while stopped
    cur_req = "R7"; cyc(0, 0, 0, 1, 0, 2'd0, 4'd10); cyc(0, 0, 0, 0, 0, 2'd0, 4'd10);
    cur_req = "R7"; ticks(2, 2'd0, 4'd10);
    // R9: manual step while stopped
    cur_req = "R9"; press_ss(2'd0, 4'd10);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 1, 0, 0, 0, 2'd0, 4'd10); cyc(0, 0, 0, 0, 0, 2'd0, 4'd10);
    end
    // R11: start and strobe coincide; reset and tick coincide
    cur_req = "R11"; cyc(1, 1, 1, 0, 0, 2'd0, 4'd10); cyc(0, 0, 0, 0, 0, 2'd0, 4'd10);
    cur_req = "R11"; ticks(3, 2'd0, 4'd10);
    cur_req = "R11"; cyc(1, 0, 0, 0, 1, 2'd0, 4'd10); cyc(0, 0, 0, 0, 0, 2'd0, 4'd10);
    // R1: random mix, every cycle compared
    cur_req = "R1";
    begin
      logic [1:0] md;
      logic [3:0] sel;
      md = 2'd0; sel = 4'd10;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom % 40 == 0) md = 2'($urandom);
        if ($urandom % 40 == 0) sel = 4'($urandom % 12);
        cyc(($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 25) == 0,
            ($urandom % 20) == 0, ($urandom % 30) == 0, md, sel);
      end
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule